// File: doc/BRIEF.md
# Pulse Time-Tag Ring Buffer

This block keeps a local time base and records a time tag whenever any of its pulse inputs fires. The time base is a 40-bit seconds count plus a sub-second count that advances once per clock cycle of 8 ns. It wraps after a parameter-set number of ticks (125,000,000 by default) and carries into the seconds.

Every clock cycle in which at least one pulse input is high produces one tag. The tag holds the mask of all channels high in that cycle, so simultaneous pulses share a single tag. It also holds a flag copied from the external-timing-valid input, the sub-second count and the seconds value. Tags go into a ring buffer of parameter depth.

A bus master reads the oldest tag through a small word-addressed register set. It reads the cycle and seconds words first, then the metadata word. Reading the metadata word removes the entry. The master can also load the seconds value and empty the buffer. It can see whether the buffer is empty or full. When the buffer is full, a new tag replaces the oldest one.

Top module: `pulse_stamp_buffer`

## Requirements
- R1: After reset, the status word (offset 6) reads 0x00020000. The seconds words (offsets 0 and 1) read 0, and the buffer is empty.
- R2: The sub-second counter rises by one each clock cycle. In the cycle after it reaches CYC_PER_SEC-1 it is 0 again, and the seconds value has risen by one, with the carry passing from bit 31 into bit 32.
- R3: A write to offset 0 loads seconds bits 31..0 from the write data. A write to offset 1 loads seconds bits 39..32 from write data bits 7..0. Either write sets the sub-second counter to 0 at the same edge. Offsets 0 and 1 read back the seconds value, with offset 1 holding bits 39..32 in bits 7..0.
- R4: Each cycle in which any pulse input is high stores exactly one tag. The tag holds the mask of the inputs high in that cycle, the sub-second count and the seconds value seen in that cycle, and the external-timing flag.
- R5: While the buffer is not empty, the words show the oldest entry. Offset 2 (metadata) holds the channel mask in bits 5..0 and the external-timing flag in bit 8. Offset 3 holds the sub-second count. Offset 4 holds seconds bits 31..0, and offset 5 holds seconds bits 39..32 in bits 7..0. While the buffer is empty, offsets 2 to 5 read 0, and so does the unused offset 7.
- R6: A read of offset 2 removes the oldest entry when the buffer is not empty. When the buffer is empty, the read returns 0 and changes nothing.
- R7: Writing bit 16 of offset 6 as 1 empties the buffer. Writing it as 0 changes nothing. A clear in the same cycle as a pulse drops that pulse's tag.
- R8: Bit 17 of offset 6 is 1 when the buffer holds no entry. Bit 18 is 1 when it holds DEPTH entries. The other bits read 0.
- R9: A tag that arrives while the buffer is full replaces the oldest entry. The buffer stays full, and the next entry shown is the second-oldest of before.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, one 8 ns tick per cycle |
| rst | input | 1 | Synchronous active-high reset |
| pulse_in | input | N_CHAN | Per-channel pulse strobes, synchronous to clk |
| ext_time_ok | input | 1 | External timing valid, stored in each tag |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe (a read of offset 2 removes the entry) |
| bus_addr | input | 3 | Register word offset |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for the current offset, combinational |

## Verification
The directed part does several things:
- It loads a known seconds value and tags a pulse in the cycle right after the load. The stored count then separates a counter that was reset by the load from one that kept running.
- It waits past a wrap, including one that starts from 0xFFFFFFFF, to show the carry into the high word.
- It fills the buffer beyond its depth with distinct masks. The surviving order shows whether the oldest entries were dropped or the newest.
- It pops an empty buffer, clears it with the bit set and with the bit clear, and clears it during a pulse.

The random part mixes pulse masks, external flags, reads, time loads and clears. It compares every read with a reference model, which exposes errors in pop and push ordering when both happen in one cycle.

// File: rtl/pst_pkg.sv
`timescale 1ns/1ps
package pst_pkg;
    localparam int TAG_CHAN_W    = 6;
    localparam int SEC_W         = 40;
    localparam int WORD_W        = 32;
    localparam int ADDR_W        = 3;
    localparam int CSR_CLR_BIT   = 16;
    localparam int CSR_EMPTY_BIT = 17;
    localparam int CSR_FULL_BIT  = 18;
    localparam int META_EXT_BIT  = 8;

    typedef enum logic [ADDR_W-1:0] {
        R_TIME_LO = 3'd0,
        R_TIME_HI = 3'd1,
        R_META    = 3'd2,
        R_CYC     = 3'd3,
        R_SEC_LO  = 3'd4,
        R_SEC_HI  = 3'd5,
        R_CSR     = 3'd6,
        R_SPARE   = 3'd7
    } reg_idx_e;

    typedef struct packed {
        logic [TAG_CHAN_W-1:0] chan;
        logic                  ext_ok;
        logic [WORD_W-1:0]     cyc;
        logic [SEC_W-1:0]      sec;
    } tag_t;

    function automatic logic [WORD_W-1:0] meta_word(input tag_t t);
        logic [WORD_W-1:0] w;
        w = '0;
        w[TAG_CHAN_W-1:0] = t.chan;
        w[META_EXT_BIT]   = t.ext_ok;
        return w;
    endfunction

    function automatic logic [WORD_W-1:0] sec_hi_word(input logic [SEC_W-1:0] s);
        logic [WORD_W-1:0] w;
        w = '0;
        w[SEC_W-WORD_W-1:0] = s[SEC_W-1:WORD_W];
        return w;
    endfunction

    function automatic logic [WORD_W-1:0] csr_word(input logic empty, input logic full);
        logic [WORD_W-1:0] w;
        w = '0;
        w[CSR_EMPTY_BIT] = empty;
        w[CSR_FULL_BIT]  = full;
        return w;
    endfunction
endpackage

// File: rtl/pst_timebase.sv
`timescale 1ns/1ps
module pst_timebase
    import pst_pkg::*;
#(
    parameter int CYC_PER_SEC = 125_000_000,
    parameter int CYC_W       = $clog2(CYC_PER_SEC)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              ld_lo,
    input  logic              ld_hi,
    input  logic [WORD_W-1:0] wdata,
    output logic [CYC_W-1:0]  cyc,
    output logic [SEC_W-1:0]  sec
);
    localparam logic [CYC_W-1:0] LAST = CYC_W'(CYC_PER_SEC - 1);

    always_ff @(posedge clk) begin
        if (rst) begin
            cyc <= '0;
            sec <= '0;
        end else if (ld_lo) begin
            sec[WORD_W-1:0] <= wdata;
            cyc             <= '0;
        end else if (ld_hi) begin
            sec[SEC_W-1:WORD_W] <= wdata[SEC_W-WORD_W-1:0];
            cyc                 <= '0;
        end else if (cyc == LAST) begin
            cyc <= '0;
            sec <= sec + 1'b1;
        end else begin
            cyc <= cyc + 1'b1;
        end
    end
endmodule

// File: rtl/pst_ring.sv
`timescale 1ns/1ps
module pst_ring
    import pst_pkg::*;
#(
    parameter int DEPTH = 16,
    parameter int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             clr,
    input  logic             push,
    input  tag_t             push_tag,
    input  logic             pop,
    output tag_t             head,
    output logic             empty,
    output logic             full,
    output logic [CNT_W-1:0] cnt
);
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;

    tag_t             slot [DEPTH];
    logic [PTR_W-1:0] rd_ptr, wr_ptr;
    logic             do_push, do_pop, adv_rd;

    function automatic logic [PTR_W-1:0] bump(input logic [PTR_W-1:0] p);
        return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    assign empty   = (cnt == '0);
    assign full    = (cnt == CNT_W'(DEPTH));
    assign do_push = push && !clr;
    assign do_pop  = pop && !empty && !clr;
    assign adv_rd  = do_pop || (do_push && full);
    assign head    = slot[rd_ptr];

    always_ff @(posedge clk) begin
        if (do_push) slot[wr_ptr] <= push_tag;
    end

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            rd_ptr <= '0;
            wr_ptr <= '0;
            cnt    <= '0;
        end else begin
            if (do_push) wr_ptr <= bump(wr_ptr);
            if (adv_rd)  rd_ptr <= bump(rd_ptr);
            if (do_push && !full && !do_pop)  cnt <= cnt + 1'b1;
            else if (do_pop && !do_push)      cnt <= cnt - 1'b1;
        end
    end
endmodule

// File: rtl/pst_regs.sv
`timescale 1ns/1ps
module pst_regs
    import pst_pkg::*;
(
    input  logic              wr,
    input  logic              rd,
    input  logic [ADDR_W-1:0] addr,
    input  logic [WORD_W-1:0] wdata,
    input  logic [SEC_W-1:0]  sec,
    input  tag_t              head,
    input  logic              empty,
    input  logic              full,
    output logic              ld_lo,
    output logic              ld_hi,
    output logic              clr,
    output logic              pop,
    output logic [WORD_W-1:0] rdata
);
    reg_idx_e idx;
    tag_t     shown;

    assign idx   = reg_idx_e'(addr);
    assign shown = empty ? '0 : head;

    always_comb begin
        ld_lo = wr && (idx == R_TIME_LO);
        ld_hi = wr && (idx == R_TIME_HI);
        clr   = wr && (idx == R_CSR) && wdata[CSR_CLR_BIT];
        pop   = rd && (idx == R_META);
        unique case (idx)
            R_TIME_LO: rdata = sec[WORD_W-1:0];
            R_TIME_HI: rdata = sec_hi_word(sec);
            R_META:    rdata = meta_word(shown);
            R_CYC:     rdata = shown.cyc;
            R_SEC_LO:  rdata = shown.sec[WORD_W-1:0];
            R_SEC_HI:  rdata = sec_hi_word(shown.sec);
            R_CSR:     rdata = csr_word(empty, full);
            default:   rdata = '0;
        endcase
    end
endmodule

// File: rtl/pulse_stamp_buffer.sv
`timescale 1ns/1ps
module pulse_stamp_buffer
    import pst_pkg::*;
#(
    parameter int N_CHAN      = 6,
    parameter int DEPTH       = 16,
    parameter int CYC_PER_SEC = 125_000_000
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [N_CHAN-1:0] pulse_in,
    input  logic              ext_time_ok,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [2:0]        bus_addr,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata
);
    localparam int CYC_W = $clog2(CYC_PER_SEC);
    localparam int CNT_W = $clog2(DEPTH + 1);

    logic [CYC_W-1:0] cyc_now;
    logic [SEC_W-1:0] sec_now;
    logic             ld_lo, ld_hi, clr_req, pop_req, push;
    logic             empty, full;
    logic [CNT_W-1:0] cnt;
    tag_t             new_tag, head;

    assign push = |pulse_in;

    always_comb begin
        new_tag        = '0;
        new_tag.chan   = TAG_CHAN_W'(pulse_in);
        new_tag.ext_ok = ext_time_ok;
        new_tag.cyc    = WORD_W'(cyc_now);
        new_tag.sec    = sec_now;
    end

    pst_timebase #(.CYC_PER_SEC(CYC_PER_SEC), .CYC_W(CYC_W)) u_time (
        .clk   (clk),
        .rst   (rst),
        .ld_lo (ld_lo),
        .ld_hi (ld_hi),
        .wdata (bus_wdata),
        .cyc   (cyc_now),
        .sec   (sec_now)
    );

    pst_ring #(.DEPTH(DEPTH), .CNT_W(CNT_W)) u_ring (
        .clk      (clk),
        .rst      (rst),
        .clr      (clr_req),
        .push     (push),
        .push_tag (new_tag),
        .pop      (pop_req),
        .head     (head),
        .empty    (empty),
        .full     (full),
        .cnt      (cnt)
    );

    pst_regs u_regs (
        .wr    (bus_wr),
        .rd    (bus_rd),
        .addr  (bus_addr),
        .wdata (bus_wdata),
        .sec   (sec_now),
        .head  (head),
        .empty (empty),
        .full  (full),
        .ld_lo (ld_lo),
        .ld_hi (ld_hi),
        .clr   (clr_req),
        .pop   (pop_req),
        .rdata (bus_rdata)
    );
endmodule

// File: rtl/pst_checker.sv
`timescale 1ns/1ps
module pst_checker
    import pst_pkg::*;
#(
    parameter int CYC_PER_SEC = 125_000_000,
    parameter int DEPTH       = 16,
    parameter int CYC_W       = $clog2(CYC_PER_SEC),
    parameter int CNT_W       = $clog2(DEPTH + 1)
) (
    input logic             clk,
    input logic             rst,
    input logic [CYC_W-1:0] cyc,
    input logic [SEC_W-1:0] sec,
    input logic             time_ld,
    input logic             clr,
    input logic             push,
    input logic             pop_req,
    input logic             empty,
    input logic             full,
    input logic [CNT_W-1:0] cnt
);
    localparam logic [CYC_W-1:0] LAST = CYC_W'(CYC_PER_SEC - 1);

    // R2: plain advance
    p_cyc_step_r2: assert property (@(posedge clk) disable iff (rst)
        (!time_ld && cyc != LAST) |=> (cyc == CYC_W'($past(cyc) + 1'b1)) && (sec == $past(sec)));

    // R2: wrap and carry
    p_cyc_wrap_r2: assert property (@(posedge clk) disable iff (rst)
        (!time_ld && cyc == LAST) |=> (cyc == '0) && (sec == $past(sec) + 1'b1));

    // R3: a time load restarts the sub-second count
    p_load_zero_r3: assert property (@(posedge clk) disable iff (rst)
        time_ld |=> (cyc == '0));

    // R6: a pop on an empty buffer changes nothing
    p_empty_pop_r6: assert property (@(posedge clk) disable iff (rst)
        (empty && pop_req && !push && !clr) |=> empty);

    // R7: clear leaves the buffer empty
    p_clear_empty_r7: assert property (@(posedge clk) disable iff (rst)
        clr |=> (empty && !full));

    // R8: flags are never both set and the count stays in range
    p_flags_r8: assert property (@(posedge clk) disable iff (rst)
        !(empty && full) && (cnt <= CNT_W'(DEPTH)));

    // R9: overwriting keeps the buffer full
    p_overwrite_full_r9: assert property (@(posedge clk) disable iff (rst)
        (full && push && !clr) |=> full);
endmodule

bind pulse_stamp_buffer pst_checker #(
    .CYC_PER_SEC (CYC_PER_SEC),
    .DEPTH       (DEPTH)
) u_chk (
    .clk     (clk),
    .rst     (rst),
    .cyc     (cyc_now),
    .sec     (sec_now),
    .time_ld (ld_lo || ld_hi),
    .clr     (clr_req),
    .push    (push),
    .pop_req (pop_req),
    .empty   (empty),
    .full    (full),
    .cnt     (cnt)
);

// File: tb/sim_pulse_stamp_buffer.sv
`timescale 1ns/1ps
module sim_pulse_stamp_buffer;
    localparam int NCH   = 6;
    localparam int DEPTH = 4;
    localparam int LIM   = 50;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [5:0]  pulse_in = '0;
    logic        ext_time_ok = 1'b0;
    logic        bus_wr = 1'b0, bus_rd = 1'b0;
    logic [2:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;

    int errors = 0;
    int checks = 0;
    bit done = 0;

    // reference model
    logic [39:0] m_sec;
    int          m_cyc;
    int          m_cnt;
    logic [5:0]  q_mask [DEPTH];
    logic        q_ext  [DEPTH];
    logic [31:0] q_cyc  [DEPTH];
    logic [39:0] q_sec  [DEPTH];
    logic [31:0] last_rd;

    always #2.5 clk = ~clk;

    pulse_stamp_buffer #(.N_CHAN(NCH), .DEPTH(DEPTH), .CYC_PER_SEC(LIM)) u0 (
        .clk(clk), .rst(rst), .pulse_in(pulse_in), .ext_time_ok(ext_time_ok),
        .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=0x%08h expected=0x%08h", req, act, exp);
        end
    endtask

    function automatic logic [31:0] exp_rd(input int a);
        logic e, f;
        e = (m_cnt == 0);
        f = (m_cnt == DEPTH);
        case (a)
            0: return m_sec[31:0];
            1: return {24'd0, m_sec[39:32]};
            2: return e ? 32'd0 : {23'd0, q_ext[0], 2'd0, q_mask[0]};
            3: return e ? 32'd0 : q_cyc[0];
            4: return e ? 32'd0 : q_sec[0][31:0];
            5: return e ? 32'd0 : {24'd0, q_sec[0][39:32]};
            6: return {13'd0, f, e, 17'd0};
            default: return 32'd0;
        endcase
    endfunction

    function automatic string req_of(input int a);
        case (a)
            0, 1: return "R3";
            2: return (m_cnt == 0) ? "R6" : "R5";
            6: return "R8";
            default: return "R5";
        endcase
    endfunction

    task automatic pop_front();
        for (int i = 0; i < DEPTH - 1; i++) begin
            q_mask[i] = q_mask[i+1]; q_ext[i] = q_ext[i+1];
            q_cyc[i]  = q_cyc[i+1];  q_sec[i] = q_sec[i+1];
        end
        m_cnt--;
    endtask

    task automatic model_step(input logic [5:0] mask, input logic ext, input logic wr,
                              input logic rd, input int a, input logic [31:0] wd);
        logic [31:0] c_cyc;
        logic [39:0] c_sec;
        c_cyc = 32'(m_cyc);
        c_sec = m_sec;
        if (wr && a == 0) begin m_sec[31:0] = wd; m_cyc = 0; end
        else if (wr && a == 1) begin m_sec[39:32] = wd[7:0]; m_cyc = 0; end
        else if (m_cyc == LIM - 1) begin m_cyc = 0; m_sec = m_sec + 1; end
        else m_cyc++;
        if (wr && a == 6 && wd[16]) m_cnt = 0;
        else begin
            if (rd && a == 2 && m_cnt > 0) pop_front();
            if (mask != 0) begin
                if (m_cnt == DEPTH) pop_front();
                q_mask[m_cnt] = mask; q_ext[m_cnt] = ext;
                q_cyc[m_cnt]  = c_cyc; q_sec[m_cnt] = c_sec;
                m_cnt++;
            end
        end
    endtask

    // one clock cycle, entered and left at a falling edge
    task automatic tick(input logic [5:0] mask, input logic ext, input logic wr,
                        input logic rd, input int a, input logic [31:0] wd);
        string r;
        logic [31:0] e;
        pulse_in = mask; ext_time_ok = ext; bus_wr = wr; bus_rd = rd;
        bus_addr = 3'(a); bus_wdata = wd;
        #1;
        last_rd = bus_rdata;
        if (rd) begin
            r = req_of(a);
            e = exp_rd(a);
            chk(r, last_rd, e);
        end
        model_step(mask, ext, wr, rd, a, wd);
        @(negedge clk);
        pulse_in = '0; bus_wr = 1'b0; bus_rd = 1'b0;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) tick(6'd0, 1'b0, 1'b0, 1'b0, 0, 32'd0);
    endtask

    task automatic rd_reg(input int a);
        tick(6'd0, 1'b0, 1'b0, 1'b1, a, 32'd0);
    endtask

    task automatic wr_reg(input int a, input logic [31:0] d);
        tick(6'd0, 1'b0, 1'b1, 1'b0, a, d);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    endtask

    initial begin
        #(200000 * 5);
        errors++;
        checks++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        finish_run();
    end

    initial begin
        void'($urandom(32'd20240611));
        m_sec = '0; m_cyc = 0; m_cnt = 0;
        repeat (4) @(negedge clk);
        rst = 1'b0;

        // R1: reset state
        rd_reg(6); chk("R1", last_rd, 32'h0002_0000);
        rd_reg(0); chk("R1", last_rd, 32'd0);
        rd_reg(1); chk("R1", last_rd, 32'd0);

        // R3/R4: load time, pulse in the next cycle sees count 0
        wr_reg(0, 32'h1234_5678);
        wr_reg(1, 32'h0000_00AB);
        tick(6'b000101, 1'b1, 1'b0, 1'b0, 0, 32'd0);
        rd_reg(3); chk("R4", last_rd, 32'd0);
        rd_reg(4); chk("R4", last_rd, 32'h1234_5678);
        rd_reg(5); chk("R4", last_rd, 32'h0000_00AB);
        rd_reg(2); chk("R5", last_rd, 32'h0000_0105);
        rd_reg(6); chk("R6", last_rd, 32'h0002_0000);

        // R2: wrap adds one second
        rd_reg(0); chk("R3", last_rd, 32'h1234_5678);
        idle(LIM);
        rd_reg(0); chk("R2", last_rd, 32'h1234_5679);

        // R2: carry into the high word
        wr_reg(0, 32'hFFFF_FFFF);
        wr_reg(1, 32'h0000_0000);
        idle(LIM);
        rd_reg(1); chk("R2", last_rd, 32'h0000_0001);
        rd_reg(0); chk("R2", last_rd, 32'h0000_0000);

        // R6: pop on empty
        rd_reg(2); chk("R6", last_rd, 32'd0);
        rd_reg(6); chk("R6", last_rd, 32'h0002_0000);

        // R9: overfill with distinct masks
        for (int i = 1; i <= DEPTH + 2; i++) tick(6'(i), 1'b0, 1'b0, 1'b0, 0, 32'd0);
        rd_reg(6); chk("R8", last_rd, 32'h0004_0000);
        rd_reg(2); chk("R9", last_rd & 32'h3F, 32'd3);
        rd_reg(2); chk("R9", last_rd & 32'h3F, 32'd4);

        // R7: clear bit 0 has no effect, clear bit 1 empties, clear beats a pulse
        wr_reg(6, 32'h0000_0000);
        rd_reg(6); chk("R7", last_rd, 32'h0000_0000);
        tick(6'b111111, 1'b1, 1'b1, 1'b0, 6, 32'h0001_0000);
        rd_reg(6); chk("R7", last_rd, 32'h0002_0000);

        // R9: full with pop and push in one cycle
        for (int i = 0; i < DEPTH; i++) tick(6'(8 + i), 1'b1, 1'b0, 1'b0, 0, 32'd0);
        tick(6'b100000, 1'b0, 1'b0, 1'b1, 2, 32'd0);
        chk("R9", last_rd & 32'h3F, 32'd8);
        rd_reg(6); chk("R9", last_rd, 32'h0004_0000);
        rd_reg(2); chk("R9", last_rd & 32'h3F, 32'd9);

        // random mix
        for (int n = 0; n < 4000; n++) begin
            logic [5:0]  mk;
            logic        ex, w, r;
            int          a, op;
            logic [31:0] d;
            mk = (($urandom % 4) == 0) ? 6'($urandom) : 6'd0;
            ex = 1'($urandom);
            op = $urandom % 100;
            a  = $urandom % 8;
            d  = $urandom;
            w = 1'b0; r = 1'b0;
            if (op < 45) r = 1'b1;
            else if (op < 49) begin w = 1'b1; a = $urandom % 2; end
            else if (op < 52) begin w = 1'b1; a = 6; end
            else if (op < 55) w = 1'b1;
            tick(mk, ex, w, r, a, d);
        end

        finish_run();
    end
endmodule